// File: doc/BRIEF.md
# Serial I/Q Frame Output Serializer

This block turns one complex baseband sample pair per sample period into a synchronous serial stream. Each frame holds a 16-bit I word and then a 16-bit Q word, both two's complement and sent MSB first. When the extra-bytes option is on, an AGC byte and then a status byte follow Q. Every bit time that carries no frame content is driven high (idle).

A divided bit clock, a frame-sync line and a serial data line make up the output. The bit clock runs at the input clock divided by a 4-bit setting. Frame timing is marked in one of two ways. The first uses a one-bit-time pulse on the frame-sync line. The second, embedded sync, drives a single low bit on the data line in the same slot and leaves the frame-sync line low.

The upstream logic presents a sample pair together with its AGC and status bytes, and pulses a strobe. The serializer latches these on the strobe and starts the frame at the next bit boundary. A strobe that arrives too early is dropped and flagged. Too early means another frame is still waiting to start, or the current frame has not yet run its minimum length.

Top module: `iq_frame_ser`

## Requirements
- R1: With divide setting d (1..15), `sclk_o` has a period of d input clock cycles. It is high for the first ceil(d/2) cycles of each bit time and low for the rest. With d = 1 it stays high. Each bit time starts on its rising edge, and `sd_o` and `fs_o` change only at bit-time starts. After reset the first bit boundary falls on the d-th input clock edge.
- R2: A divide setting of 0 behaves exactly like a setting of 1.
- R3: A frame starts with a one-bit sync slot. Data bit 1 is I[15], bit 16 is I[0], bit 17 is Q[15] and bit 32 is Q[0].
- R4: With embedded sync off, `fs_o` is high for exactly the sync slot and low at all other times. `sd_o` is high during that slot.
- R5: With embedded sync on, `fs_o` stays low and `sd_o` is low during the sync slot.
- R6: With the extra-bytes option on, data bits 33..40 carry the AGC byte MSB first and bits 41..48 carry the status byte MSB first.
- R7: `sd_o` is high after the last data bit of a frame and at all times before the first frame.
- R8: An accepted strobe starts its frame at the first bit boundary that falls strictly after the input clock edge where the strobe was sampled. The option bits are latched together with the data at that edge.
- R9: Count the bit times after the sync slot of the current frame. A strobe is rejected if a frame is pending or if this count is below a minimum length. The minimum is 32 with both options off, 48 with extra bytes only, 49 with embedded sync only and 69 with both. A rejected strobe raises `overrun_o` for one input clock cycle after the sampling edge, and its data is never sent.
- R10: During and right after reset, `sd_o` = 1, `fs_o` = 0, `overrun_o` = 0 and `sclk_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (modulator-rate) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 4 | Bit-clock divide setting, 0 treated as 1 |
| xbytes_en_i | input | 1 | Append AGC and status bytes after Q |
| esync_en_i | input | 1 | Embedded sync instead of the frame-sync pulse |
| strobe_i | input | 1 | New sample pair valid, one cycle |
| i_smp_i | input | 16 | I sample, two's complement |
| q_smp_i | input | 16 | Q sample, two's complement |
| agc_byte_i | input | 8 | AGC byte |
| stat_byte_i | input | 8 | Status byte |
| sclk_o | output | 1 | Divided bit clock |
| fs_o | output | 1 | Frame-sync pulse |
| sd_o | output | 1 | Serial data, idle high |
| overrun_o | output | 1 | Strobe dropped, one-cycle pulse |

## Verification
The bench builds the block with its default 16-bit samples, 8-bit extra bytes and 4-bit divider. At these sizes every divide code from 0 to 15 can be combined with all four option combinations, and each bit of a frame can be predicted by arithmetic from the strobe cycle. For divide codes 0 to 4, the bench places strobes exactly one cycle before and one cycle after the minimum-length boundary, and a third strobe while a frame is pending. This exercises both the acceptance and the drop of a sample.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
  localparam int SMP_W = 16;
  localparam int EXT_W = 8;
  localparam int FRM_W = 2 * SMP_W + 2 * EXT_W;
  localparam int LEN_W = 7;
  localparam int DIV_W = 4;

  typedef struct packed {
    logic [SMP_W-1:0] i_smp;
    logic [SMP_W-1:0] q_smp;
    logic [EXT_W-1:0] agc;
    logic [EXT_W-1:0] stat;
  } frame_t;

  // minimum bit times after the sync slot before a new strobe is taken
  function automatic logic [LEN_W-1:0] min_len(input logic xb, input logic es);
    logic [LEN_W-1:0] r;
    unique case ({xb, es})
      2'b00:   r = LEN_W'(32);
      2'b01:   r = LEN_W'(49);
      2'b10:   r = LEN_W'(48);
      default: r = LEN_W'(69);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ser_clk_div.sv
module ser_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] d_eff, cnt_q, cnt_n;
  logic [DIV_W:0]   hi_len;
  logic             sclk_q;

  always_comb begin
    d_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
    hi_len = ({1'b0, d_eff} + (DIV_W + 1)'(1)) >> 1;
    tick_o = (cnt_q >= d_eff - DIV_W'(1));
    cnt_n  = tick_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      sclk_q <= ({1'b0, cnt_n} < hi_len);
    end
  end

  assign sclk_o = sclk_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < d_eff);

  // R1
  bit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && d_eff > DIV_W'(1) && $stable(div_i)) |=> $rose(sclk_o));
endmodule

// File: rtl/ser_strobe_gate.sv
module ser_strobe_gate
  import iq_ser_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   strobe_i,
  input  frame_t frame_i,
  input  logic   xb_i,
  input  logic   es_i,
  input  logic   tick_i,
  input  logic   open_i,
  output logic   start_o,
  output frame_t frame_o,
  output logic   xb_o,
  output logic   es_o,
  output logic   overrun_o
);
  logic   pend_q, xb_q, es_q, ovr_q, accept;
  frame_t frm_q;

  assign accept  = strobe_i & ~pend_q & open_i;
  assign start_o = pend_q & tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      xb_q   <= 1'b0;
      es_q   <= 1'b0;
      frm_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= strobe_i & ~accept;
      if (accept) begin
        pend_q <= 1'b1;
        frm_q  <= frame_i;
        xb_q   <= xb_i;
        es_q   <= es_i;
      end else if (start_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign frame_o   = frm_q;
  assign xb_o      = xb_q;
  assign es_o      = es_q;
  assign overrun_o = ovr_q;

  // R9
  pend_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && pend_q) |=> overrun_o);

  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tick_i) |=> pend_q);
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift
  import iq_ser_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   start_i,
  input  frame_t frame_i,
  input  logic   xb_i,
  input  logic   es_i,
  output logic   open_o,
  output logic   sd_o,
  output logic   fs_o
);
  localparam int REM_W = $clog2(FRM_W + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [FRM_W-1:0] sr_q;
  logic [REM_W-1:0] rem_q;
  logic [LEN_W-1:0] len_q, lmin_q;
  logic             started_q, sd_q, fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      rem_q     <= '0;
      len_q     <= '0;
      lmin_q    <= '0;
      started_q <= 1'b0;
      sd_q      <= 1'b1;
      fs_q      <= 1'b0;
    end else if (tick_i) begin
      if (start_i) begin
        sr_q      <= frame_i;
        rem_q     <= xb_i ? REM_W'(FRM_W) : REM_W'(2 * SMP_W);
        len_q     <= '0;
        lmin_q    <= min_len(xb_i, es_i);
        started_q <= 1'b1;
        sd_q      <= ~es_i;
        fs_q      <= ~es_i;
      end else begin
        fs_q  <= 1'b0;
        len_q <= (len_q == LEN_MAX) ? len_q : len_q + LEN_W'(1);
        if (rem_q != '0) begin
          sd_q  <= sr_q[FRM_W-1];
          sr_q  <= sr_q << 1;
          rem_q <= rem_q - REM_W'(1);
        end else begin
          sd_q <= 1'b1;
        end
      end
    end
  end

  assign open_o = ~started_q | (len_q >= lmin_q);
  assign sd_o   = sd_q;
  assign fs_o   = fs_q;

  // R4
  fs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_o) |-> sd_o);

  // R7
  pre_frame_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> sd_o);
endmodule

// File: rtl/iq_frame_ser.sv
module iq_frame_ser
  import iq_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             xbytes_en_i,
  input  logic             esync_en_i,
  input  logic             strobe_i,
  input  logic [SMP_W-1:0] i_smp_i,
  input  logic [SMP_W-1:0] q_smp_i,
  input  logic [EXT_W-1:0] agc_byte_i,
  input  logic [EXT_W-1:0] stat_byte_i,
  output logic             sclk_o,
  output logic             fs_o,
  output logic             sd_o,
  output logic             overrun_o
);
  logic   tick_w, start_w, open_w, xb_w, es_w;
  frame_t in_frm, pend_frm;

  assign in_frm = '{i_smp: i_smp_i, q_smp: q_smp_i, agc: agc_byte_i, stat: stat_byte_i};

  ser_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .tick_o(tick_w),
    .sclk_o(sclk_o)
  );

  ser_strobe_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .frame_i  (in_frm),
    .xb_i     (xbytes_en_i),
    .es_i     (esync_en_i),
    .tick_i   (tick_w),
    .open_i   (open_w),
    .start_o  (start_w),
    .frame_o  (pend_frm),
    .xb_o     (xb_w),
    .es_o     (es_w),
    .overrun_o(overrun_o)
  );

  ser_frame_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_w),
    .start_i(start_w),
    .frame_i(pend_frm),
    .xb_i   (xb_w),
    .es_i   (es_w),
    .open_o (open_w),
    .sd_o   (sd_o),
    .fs_o   (fs_o)
  );

  // R8
  start_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> $rose(sclk_o) || (sclk_o && $past(sclk_o)));
endmodule

// File: tb/tb_iq_frame_ser.sv
module tb_iq_frame_ser;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  div_i = '0;
  logic        xbytes_en_i = 1'b0, esync_en_i = 1'b0, strobe_i = 1'b0;
  logic [15:0] i_smp_i = '0, q_smp_i = '0;
  logic [7:0]  agc_byte_i = '0, stat_byte_i = '0;
  logic        sclk_o, fs_o, sd_o, overrun_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  iq_frame_ser dut (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  task automatic chk(input logic act, input logic exp, input string tag, input int c);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b cyc=%0d div=%0d xb=%0b es=%0b",
               tag, act, exp, c, div_i, xbytes_en_i, esync_en_i);
    end
  endtask

  task automatic drive(input logic [47:0] w);
    {i_smp_i, q_smp_i, agc_byte_i, stat_byte_i} = w;
  endtask

  task automatic run_cfg(input int dv, input bit xb, input bit es, input bit ovr, input int k);
    int d, nd, lmin, c0, t1, ra, t2, end_c, base, j;
    logic [47:0] w1, w2, w3, wf;
    logic exp_sd, exp_fs;
    string tag;
    d    = (dv == 0) ? 1 : dv;
    nd   = xb ? 48 : 32;
    lmin = xb ? (es ? 69 : 48) : (es ? 49 : 32);
    w1 = {16'h8001 ^ 16'(k * 16'h0357), 16'h7FFE ^ 16'(k * 16'h1111), 8'hA5 ^ 8'(k), 8'h3C + 8'(k)};
    w2 = ~w1 ^ 48'h0F0F_33CC_5A5A;
    w3 = 48'h0;
    @(negedge clk_i);
    rst_ni = 1'b0; strobe_i = 1'b0;
    div_i = 4'(dv); xbytes_en_i = xb; esync_en_i = es;
    drive(w3);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    chk(sd_o, 1'b1, "R10 sd", 0);
    chk(fs_o, 1'b0, "R10 fs", 0);
    chk(overrun_o, 1'b0, "R10 ovr", 0);
    chk(sclk_o, 1'b1, "R10 sclk", 0);
    c0 = 3;
    t1 = ((c0 + 1) / d + 1) * d;
    ra = t1 + lmin * d;
    t2 = ((ra + 1) / d + 1) * d;
    end_c = ovr ? t2 + (nd + 3) * d : t1 + (nd + 3) * d;
    // input changes at xb/es after acceptance must not matter (R8)
    forever begin
      @(negedge clk_i);
      if (cyc == c0) begin strobe_i = 1'b1; drive(w1); end
      if (cyc == c0 + 1) begin strobe_i = 1'b0; xbytes_en_i = ~xb; esync_en_i = ~es; end
      if (cyc == t1 + 1) begin xbytes_en_i = xb; esync_en_i = es; end
      if (ovr) begin
        if (cyc == ra - 1) begin strobe_i = 1'b1; drive(w3); end
        if (cyc == ra)     drive(w2);
        if (cyc == ra + 1) drive(w3);
        if (cyc == ra + 2) strobe_i = 1'b0;
      end
      chk(sclk_o, ((cyc % d) < (d + 1) / 2), (dv == 0) ? "R2 sclk" : "R1 sclk", cyc);
      // R9 overrun pulses: early strobe and strobe while pending
      chk(overrun_o, ovr && (cyc == ra || cyc == ra + 2), "R9 overrun", cyc);
      if (cyc < t1) begin
        chk(sd_o, 1'b1, "R8 sd before start", cyc);
        chk(fs_o, 1'b0, "R8 fs before start", cyc);
      end else begin
        if (ovr && cyc >= t2) begin base = t2; wf = w2; end
        else begin base = t1; wf = w1; end
        if ((cyc - base) % d == 0) begin
          j = (cyc - base) / d;
          if (j == 0)        begin exp_sd = ~es; tag = es ? "R5 slot" : "R4 slot"; end
          else if (j <= nd)  begin exp_sd = wf[48 - j]; tag = (j > 32) ? "R6 xbyte" : "R3 data"; end
          else               begin exp_sd = 1'b1; tag = "R7 idle"; end
          if (base == t2 && j > 0 && j <= nd) tag = "R9 kept sample";
          exp_fs = (j == 0) && !es;
          chk(sd_o, exp_sd, tag, cyc);
          chk(fs_o, exp_fs, es ? "R5 fs" : "R4 fs", cyc);
        end
      end
      if (cyc >= end_c) break;
    end
  endtask

  initial begin
    int k = 0;
    for (int dv = 0; dv < 16; dv++)
      for (int m = 0; m < 4; m++) begin
        run_cfg(dv, m[1], m[0], dv <= 4, k);
        k++;
      end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule